// File: doc/BRIEF.md
# TDM Serial Audio Output Port

This block is the clock-master transmit side of a time-division-multiplexed audio link. It runs on the bit clock and produces the frame sync and one serial data line. It also produces an output-enable that lets a pad driver release the data line. A frame has 48 slots of 8 bits each, 384 bit clocks in total. Four converter channels each place a 16-bit sample into two consecutive slots, starting at a slot chosen per channel.

The sample words arrive in parallel with a load strobe and are held in a staging register. They are copied into the frame buffer once per frame, just before the first bit goes out. A load during a frame therefore only affects the next frame. The frame sync high time is either half of the frame or a programmed number of bit clocks. The data line can optionally lead the frame by half a bit clock. A 48-bit slot mask chooses which slots are driven. In every other slot the output-enable is low.

Top module: `tdm_out_port`

## Requirements
- R1: One frame is 384 bit clocks (48 slots of 8 bits). `fsync` rises at bit position 0 of each frame and repeats every 384 bit clocks.
- R2: With `fs_half_mode` = 1, `fsync` is high for positions 0..191. With `fs_half_mode` = 0, it is high for positions below `fs_high_len`, where `fs_high_len` can be any value from 1 to 384.
- R3: Bit position p belongs to slot p/8. `sdata_oe` equals `slot_mask[p/8]`. While `sdata_oe` is low, `sdata` is 0.
- R4: Channel c takes its sample from `smp_data[16c+15:16c]` and its start slot s from `chan_start[6c+5:6c]`. Slot s carries bits 15..8 and slot s+1 carries bits 7..0, each slot MSB first.
- R5: When enabled channels claim the same slot, the lowest-numbered channel supplies the data.
- R6: A slot that is enabled in the mask but claimed by no enabled channel drives 0 with `sdata_oe` high. A channel with `chan_on[c]` = 0 claims no slot.
- R7: With `early_launch` = 1, the value for position p appears on the rising edge in the middle of position p-1, half a bit clock ahead of the normal timing.
- R8: With `early_launch` = 0, `fsync`, `sdata` and `sdata_oe` change only on falling edges of `bclk`, so they hold steady across the rising edge.
- R9: `smp_load` captures `smp_data` on a rising edge. The captured words take effect only from the next frame start, so a load during a frame leaves that frame unchanged.
- R10: While `rst` is high, `fsync` and `sdata_oe` are low. The first falling edge after `rst` is released begins position 0 of a frame.
- R11: A channel starting at slot 47 sends only its high byte. A start slot of 48 or more places nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_load | input | 1 | Capture strobe for `smp_data` |
| smp_data | input | 64 | Four 16-bit samples, channel c at bits 16c+15:16c |
| fs_half_mode | input | 1 | 1: frame sync high for half of the frame; 0: high for the programmed length |
| fs_high_len | input | 9 | Programmed frame sync high time in bit clocks |
| early_launch | input | 1 | Launch data half a bit clock early |
| slot_mask | input | 48 | Per-slot drive enable |
| chan_on | input | 4 | Per-channel enable |
| chan_start | input | 24 | Start slot per channel, 6 bits each |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Data output-enable; low means high impedance |

## Verification
The serializer is run with a directed set of layouts: channels in separate slots with a full mask, channels that overlap, a channel at the last slot, a channel whose start slot is out of range, and all channels disabled. These runs tell apart errors in byte order, channel priority, boundary handling and zero fill. Further layouts come from a fixed seed. They draw the mask, the channel enables, the start slots, the frame sync mode and length, and the launch timing at random, and they expose mistakes in decoding the slot index and the mask. Every layout is checked over three frames, with loads in the first and middle frames. This shows that a sample takes effect only at a frame boundary. Sampling in both halves of each bit separates normal from early launch timing.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    typedef enum logic {
        FS_PROGRAMMED = 1'b0,
        FS_HALF       = 1'b1
    } fs_sel_e;

    // number of slots one sample spans
    function automatic int span_of(int sample_w, int slot_w);
        return (sample_w + slot_w - 1) / slot_w;
    endfunction

endpackage

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
    import tdm_pkg::*;
#(
    parameter int FRAME_BITS = 384,
    parameter int POS_W      = 9,
    parameter int LEN_W      = 9
) (
    input  logic [POS_W-1:0] pos,
    input  fs_sel_e          mode,
    input  logic [LEN_W-1:0] high_len,
    output logic             level
);
    localparam int HALF = FRAME_BITS / 2;

    always_comb begin
        if (mode == FS_HALF) level = (int'(pos) < HALF);
        else                 level = (int'(pos) < int'(high_len));
    end
endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map
    import tdm_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SLOTS    = 48,
    parameter int SLOT_W   = 8,
    parameter int SAMPLE_W = 16,
    parameter int POS_W    = 9,
    parameter int IDX_W    = 6
) (
    input  logic [POS_W-1:0]           pos,
    input  logic [NUM_CH*SAMPLE_W-1:0] samples,
    input  logic [NUM_CH-1:0]          chan_on,
    input  logic [NUM_CH*IDX_W-1:0]    chan_start,
    input  logic [SLOTS-1:0]           slot_mask,
    output logic                       bit_val,
    output logic                       drive
);
    localparam int SPAN   = span_of(SAMPLE_W, SLOT_W);
    localparam int BUS_W  = NUM_CH * SAMPLE_W;
    localparam int BUS_IW = $clog2(BUS_W);
    localparam int SIW    = $clog2(SLOTS);

    int               slot_i;
    int               bit_i;
    int               off_i;
    int               src_i;
    logic [BUS_IW-1:0] src_idx;
    logic [SIW-1:0]   slot_idx;
    logic             hit;
    logic             val;

    always_comb begin
        slot_i   = int'(pos) / SLOT_W;
        bit_i    = int'(pos) % SLOT_W;
        slot_idx = SIW'(slot_i);
        hit      = 1'b0;
        val      = 1'b0;
        off_i    = 0;
        src_i    = 0;
        src_idx  = '0;
        // walk from the highest channel down so the lowest wins
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            off_i = slot_i - int'(chan_start[c*IDX_W +: IDX_W]);
            if (chan_on[c] && off_i >= 0 && off_i < SPAN) begin
                src_i = SAMPLE_W - 1 - (off_i * SLOT_W + bit_i);
                hit   = 1'b1;
                if (src_i >= 0) begin
                    src_idx = BUS_IW'(c * SAMPLE_W + src_i);
                    val     = samples[src_idx];
                end else begin
                    val = 1'b0;
                end
            end
        end
        drive   = (slot_i < SLOTS) ? slot_mask[slot_idx] : 1'b0;
        bit_val = drive & hit & val;
    end
endmodule

// File: rtl/tdm_out_port.sv
module tdm_out_port
    import tdm_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SLOTS    = 48,
    parameter int SLOT_W   = 8,
    parameter int SAMPLE_W = 16,
    localparam int FRAME_BITS = SLOTS * SLOT_W,
    localparam int LEN_W      = $clog2(FRAME_BITS + 1),
    localparam int IDX_W      = $clog2(SLOTS)
) (
    input  logic                       bclk,
    input  logic                       rst,
    input  logic                       smp_load,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic                       fs_half_mode,
    input  logic [LEN_W-1:0]           fs_high_len,
    input  logic                       early_launch,
    input  logic [SLOTS-1:0]           slot_mask,
    input  logic [NUM_CH-1:0]          chan_on,
    input  logic [NUM_CH*IDX_W-1:0]    chan_start,
    output logic                       fsync,
    output logic                       sdata,
    output logic                       sdata_oe
);
    localparam int POS_W = $clog2(FRAME_BITS);
    localparam int BUS_W = NUM_CH * SAMPLE_W;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    // state launched on the falling edge
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             fsync;
        logic             dat;
        logic             oe;
    } fall_st_t;

    // state captured on the rising edge
    typedef struct packed {
        logic [BUS_W-1:0] pend;
        logic [BUS_W-1:0] frame;
        logic             dat;
        logic             oe;
    } rise_st_t;

    fall_st_t         f_d, f_q;
    rise_st_t         r_d, r_q;
    logic             wrap;
    logic [POS_W-1:0] pos_nxt;
    logic [BUS_W-1:0] frame_nxt;
    logic             fs_lvl;
    logic             fall_bit, fall_drv;
    logic             rise_bit, rise_drv;

    assign wrap      = (f_q.pos == LAST_POS);
    assign pos_nxt   = wrap ? '0 : f_q.pos + 1'b1;
    // the staging words become the frame words on the last rising edge of a frame
    assign frame_nxt = wrap ? r_q.pend : r_q.frame;

    tdm_fsync_gen #(
        .FRAME_BITS(FRAME_BITS), .POS_W(POS_W), .LEN_W(LEN_W)
    ) u_fs (
        .pos(pos_nxt), .mode(fs_sel_e'(fs_half_mode)),
        .high_len(fs_high_len), .level(fs_lvl)
    );

    tdm_slot_map #(
        .NUM_CH(NUM_CH), .SLOTS(SLOTS), .SLOT_W(SLOT_W),
        .SAMPLE_W(SAMPLE_W), .POS_W(POS_W), .IDX_W(IDX_W)
    ) u_map_fall (
        .pos(pos_nxt), .samples(r_q.frame), .chan_on(chan_on),
        .chan_start(chan_start), .slot_mask(slot_mask),
        .bit_val(fall_bit), .drive(fall_drv)
    );

    tdm_slot_map #(
        .NUM_CH(NUM_CH), .SLOTS(SLOTS), .SLOT_W(SLOT_W),
        .SAMPLE_W(SAMPLE_W), .POS_W(POS_W), .IDX_W(IDX_W)
    ) u_map_rise (
        .pos(pos_nxt), .samples(frame_nxt), .chan_on(chan_on),
        .chan_start(chan_start), .slot_mask(slot_mask),
        .bit_val(rise_bit), .drive(rise_drv)
    );

    always_comb begin
        f_d = f_q;
        if (rst) begin
            f_d.pos   = LAST_POS;
            f_d.fsync = 1'b0;
            f_d.dat   = 1'b0;
            f_d.oe    = 1'b0;
        end else begin
            f_d.pos   = pos_nxt;
            f_d.fsync = fs_lvl;
            f_d.dat   = fall_bit;
            f_d.oe    = fall_drv;
        end
    end

    always_ff @(negedge bclk) f_q <= f_d;

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.pend  = '0;
            r_d.frame = '0;
            r_d.dat   = 1'b0;
            r_d.oe    = 1'b0;
        end else begin
            if (smp_load) r_d.pend = smp_data;
            r_d.frame = frame_nxt;
            r_d.dat   = rise_bit;
            r_d.oe    = rise_drv;
        end
    end

    always_ff @(posedge bclk) r_q <= r_d;

    assign fsync    = f_q.fsync;
    assign sdata    = early_launch ? r_q.dat : f_q.dat;
    assign sdata_oe = early_launch ? r_q.oe  : f_q.oe;
endmodule

// File: rtl/tdm_out_port_chk.sv
module tdm_out_port_chk #(
    parameter int FRAME_BITS = 384,
    parameter int LEN_W      = 9,
    parameter int SLOTS      = 48,
    parameter int NUM_CH     = 4
) (
    input logic             bclk,
    input logic             rst,
    input logic             fs_half_mode,
    input logic [LEN_W-1:0] fs_high_len,
    input logic             early_launch,
    input logic [SLOTS-1:0] slot_mask,
    input logic [NUM_CH-1:0] chan_on,
    input logic             fsync,
    input logic             sdata,
    input logic             sdata_oe
);
    localparam logic [LEN_W:0] PERIOD_M1 = (LEN_W+1)'(FRAME_BITS - 1);
    localparam logic [LEN_W:0] HALF_LEN  = (LEN_W+1)'(FRAME_BITS / 2);

    logic           fs_prev;
    logic           seen;
    logic           hi_ok;
    logic [LEN_W:0] per_cnt;
    logic [LEN_W:0] hi_cnt;
    logic [LEN_W:0] cfg_prev;
    logic [LEN_W:0] exp_hi;

    assign exp_hi = fs_half_mode ? HALF_LEN : {1'b0, fs_high_len};

    always_ff @(negedge bclk) begin
        if (rst) begin
            fs_prev  <= 1'b0;
            seen     <= 1'b0;
            hi_ok    <= 1'b0;
            per_cnt  <= '0;
            hi_cnt   <= '0;
            cfg_prev <= {fs_half_mode, fs_high_len};
        end else begin
            fs_prev  <= fsync;
            cfg_prev <= {fs_half_mode, fs_high_len};
            if (fsync && !fs_prev) begin
                per_cnt <= '0;
                hi_cnt  <= (LEN_W+1)'(1);
                seen    <= 1'b1;
                hi_ok   <= 1'b1;
            end else begin
                per_cnt <= per_cnt + 1'b1;
                if (fsync) hi_cnt <= hi_cnt + 1'b1;
            end
            if (cfg_prev != {fs_half_mode, fs_high_len}) begin
                seen  <= 1'b0;
                hi_ok <= 1'b0;
            end
        end
    end

    assert_fsync_low_in_reset_R10: assert property (@(negedge bclk)
        rst |=> !fsync);

    assert_frame_period_R1: assert property (@(negedge bclk) disable iff (rst)
        (fsync && !fs_prev && seen) |-> (per_cnt == PERIOD_M1));

    assert_high_time_R2: assert property (@(negedge bclk) disable iff (rst)
        (!fsync && fs_prev && hi_ok) |-> (hi_cnt == exp_hi));

    assert_masked_slots_quiet_R3: assert property (@(negedge bclk) disable iff (rst)
        (!early_launch && $past(!early_launch) && ($past(slot_mask) == '0)) |-> !sdata_oe);

    assert_idle_channels_zero_R6: assert property (@(negedge bclk) disable iff (rst)
        (!early_launch && $past(!early_launch) && ($past(chan_on) == '0)) |-> !sdata);
endmodule

bind tdm_out_port tdm_out_port_chk #(
    .FRAME_BITS(FRAME_BITS), .LEN_W(LEN_W), .SLOTS(SLOTS), .NUM_CH(NUM_CH)
) u_chk (
    .bclk(bclk), .rst(rst), .fs_half_mode(fs_half_mode), .fs_high_len(fs_high_len),
    .early_launch(early_launch), .slot_mask(slot_mask), .chan_on(chan_on),
    .fsync(fsync), .sdata(sdata), .sdata_oe(sdata_oe)
);

// File: tb/sim_tdm_out_port.sv
module sim_tdm_out_port;
    localparam int FRAME = 384;

    logic        bclk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_load = 1'b0;
    logic [63:0] smp_data = '0;
    logic        fs_half_mode = 1'b1;
    logic [8:0]  fs_high_len = 9'd1;
    logic        early_launch = 1'b0;
    logic [47:0] slot_mask = '0;
    logic [3:0]  chan_on = '0;
    logic [23:0] chan_start = '0;
    logic        fsync, sdata, sdata_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 bclk = ~bclk;

    tdm_out_port u0 (
        .bclk(bclk), .rst(rst), .smp_load(smp_load), .smp_data(smp_data),
        .fs_half_mode(fs_half_mode), .fs_high_len(fs_high_len),
        .early_launch(early_launch), .slot_mask(slot_mask), .chan_on(chan_on),
        .chan_start(chan_start), .fsync(fsync), .sdata(sdata), .sdata_oe(sdata_oe)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected {oe, data} for bit position p with frame samples smp
    function automatic logic [1:0] exp_bit(int p, logic [63:0] smp);
        int slot = p / 8;
        int b = p % 8;
        int off;
        logic oe = slot_mask[slot];
        logic d = 1'b0;
        for (int c = 3; c >= 0; c--) begin
            off = slot - int'(chan_start[c*6 +: 6]);
            if (chan_on[c] && off >= 0 && off < 2) d = smp[c*16 + 15 - (off*8 + b)];
        end
        return {oe, oe & d};
    endfunction

    function automatic logic exp_fs(int p);
        if (fs_half_mode) return p < FRAME/2;
        return p < int'(fs_high_len);
    endfunction

    task automatic run_scn(string tag, logic [63:0] smp_a, logic [63:0] smp_b);
        logic [63:0] pend_m, frame_m;
        logic [1:0]  e, e2;
        string       dtag;
        rst = 1'b1;
        smp_load = 1'b0;
        repeat (3) @(negedge bclk);
        #5;
        chk("R10 fsync in reset", {31'd0, fsync}, 32'd0);
        chk("R10 oe in reset", {31'd0, sdata_oe}, 32'd0);
        rst = 1'b0;
        pend_m = '0;
        frame_m = '0;
        for (int f = 0; f < 3; f++) begin
            for (int p = 0; p < FRAME; p++) begin
                @(negedge bclk);
                #5;
                if (p == 0) frame_m = pend_m;
                e = exp_bit(p, frame_m);
                dtag = (f == 1 && p > 100) ? {tag, " R9 frame held"} : {tag, " data"};
                chk("R1 R2 fsync", {31'd0, fsync}, {31'd0, exp_fs(p)});
                chk("R3 oe", {31'd0, sdata_oe}, {31'd0, e[1]});
                chk(dtag, {31'd0, sdata}, {31'd0, e[0]});
                if (f == 0 && p == 10) begin
                    smp_data = smp_a; smp_load = 1'b1; pend_m = smp_a;
                end else if (f == 1 && p == 100) begin
                    smp_data = smp_b; smp_load = 1'b1; pend_m = smp_b;
                end else begin
                    smp_load = 1'b0; smp_data = {$urandom, $urandom};
                end
                @(posedge bclk);
                #5;
                if (early_launch) begin
                    if (p < FRAME - 1) begin
                        e2 = exp_bit(p + 1, frame_m);
                        chk("R7 early data", {31'd0, sdata}, {31'd0, e2[0]});
                        chk("R7 early oe", {31'd0, sdata_oe}, {31'd0, e2[1]});
                    end
                end else begin
                    chk("R8 data held", {31'd0, sdata}, {31'd0, e[0]});
                    chk("R8 fsync held", {31'd0, fsync}, {31'd0, exp_fs(p)});
                end
            end
        end
        smp_load = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R4: separate slots, full mask, half-frame sync
        fs_half_mode = 1'b1; early_launch = 1'b0;
        slot_mask = {48{1'b1}}; chan_on = 4'hF;
        chan_start = {6'd6, 6'd4, 6'd2, 6'd0};
        run_scn("R4", 64'h1234_A5C3_F00F_8001, 64'hFEDC_0F0F_3C3C_7E81);
        // R7 with R2: one-clock sync pulse, early launch
        fs_half_mode = 1'b0; fs_high_len = 9'd1; early_launch = 1'b1;
        chan_start = {6'd40, 6'd30, 6'd20, 6'd10};
        run_scn("R7", 64'hBEEF_CAFE_1357_9BDF, 64'h0246_8ACE_FFFF_0000);
        // R5: overlap, long sync pulse
        fs_high_len = 9'd200; early_launch = 1'b0;
        chan_start = {6'd30, 6'd6, 6'd5, 6'd5};
        run_scn("R5", 64'h5A5A_C33C_9696_E1E1, 64'h1111_2222_3333_4444);
        // R11 with R3: last slot, out-of-range start, partial mask
        fs_high_len = 9'd9; early_launch = 1'b1;
        slot_mask = 48'h0F0F_F0F0_AAAA; chan_on = 4'b1011;
        chan_start = {6'd20, 6'd0, 6'd50, 6'd47};
        slot_mask[47] = 1'b1; slot_mask[46] = 1'b1;
        run_scn("R11", 64'h8421_7BDE_6006_F00D, 64'hDEAD_BEEF_0123_4567);
        // R6: no channels, enabled slots drive zero
        fs_half_mode = 1'b1; early_launch = 1'b0;
        slot_mask = {48{1'b1}}; chan_on = 4'h0;
        run_scn("R6", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        // random layouts
        for (int k = 0; k < 4; k++) begin
            fs_half_mode = 1'($urandom % 2);
            fs_high_len  = 9'(1 + $urandom % 383);
            early_launch = 1'($urandom % 2);
            slot_mask    = {16'($urandom), 32'($urandom)};
            chan_on      = 4'($urandom);
            for (int c = 0; c < 4; c++) chan_start[c*6 +: 6] = 6'($urandom % 52);
            run_scn("R4 R5 random", {$urandom, $urandom}, {$urandom, $urandom});
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end
endmodule